// File: doc/BRIEF.md
# USB Host Clock and Reset Power-Up Sequencer

This block powers up a USB host controller and its PHY once software asks for it. A reference counter tracks start and stop requests. Only the start that moves the count from zero to one launches the hardware sequence. Any start after that, while the count is above zero, only adds to the count.

Once launched, the sequencer follows a fixed order:
- It selects the PHY reference clock source and its divider code.
- It loads a host-clock divider picked from the I/O clock rate.
- It enables that divider and takes it out of reset, then releases PHY power-on reset.
- It brings up the low-speed divider.
- It applies a high/low/high pattern to the PHY reset control and finally releases host reset.

The micro-frame length adjust value is written last. A done flag pulses for one cycle when the sequence ends. If the host is already out of reset at launch, the sequence is skipped and the block goes straight to the frame-length step. Starting the controller again would otherwise cause bus errors.

Every wait comes from one shared down-counter. The block is clocked by the I/O clock. The waits of 1 µs, 1 ms and 3 ms are derived from the `CYC_PER_US` and `US_PER_MS` parameters. The 64-cycle I/O waits come from `IO_WAIT`.

Top module: `usb_pwrup_seq`

## Requirements
- R1: After reset, every control output, the reference count, `rate_err_o`, `frame_adj_o` and `done_o` are 0.
- R2: A start with no stop in the same cycle, while the count is 0, launches the sequence and sets the count to 1. A later start only increments the count. A stop decrements it. A start together with a stop leaves the count unchanged and launches nothing.
- R3: The count saturates at 2^CNT_W-1. A stop while the count is 0 is ignored.
- R4: If `already_up_i` is 1 or `host_rst_n_o` is already 1 at launch, no control output changes. `frame_adj_o` becomes 0x20 and `done_o` pulses in the cycle after launch.
- R5: In the cycle after a full launch, `phy_por_o` is 1. `host_rst_n_o`, `phy_rst_o`, both divider enables and both divider reset releases are 0.
- R6: `refclk_ext_o` is 0 for a crystal (`crystal_i`=1) and 1 otherwise. `refclk_div_o` is 0, 1 or 2 for a `ref_mhz_i` of 12, 24 or 48. Any other rate gives code 0 and sets `rate_err_o` to 1.
- R7: `hclk_div_o` is derived from b = `io_mhz_i`/130 (integer division): b=0 gives 1, b=1..4 gives b, b=5 gives 4, b=6..7 gives 6, b=8..11 gives 8, and b≥12 gives 12.
- R8: `hdiv_en_o` rises one cycle before `hdiv_rst_n_o`. `phy_por_o` falls exactly `IO_WAIT` cycles after `hdiv_rst_n_o` rises.
- R9: `ldiv_rst_n_o` rises 3·US_PER_MS·CYC_PER_US cycles after `phy_por_o` falls. `ldiv_en_o` rises one cycle later. `phy_rst_o` first rises `IO_WAIT` cycles after that.
- R10: `phy_rst_o` stays high for CYC_PER_US cycles, then low for US_PER_MS·CYC_PER_US cycles, then high again. `host_rst_n_o` rises CYC_PER_US cycles after the second rise.
- R11: One cycle after `host_rst_n_o` rises, `frame_adj_o` is 0x20 and `done_o` is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request strobe |
| stop_i | input | 1 | Stop request strobe |
| crystal_i | input | 1 | 1 = reference is a crystal |
| ref_mhz_i | input | 8 | Reference clock rate in MHz |
| io_mhz_i | input | IO_W | I/O clock rate in MHz |
| already_up_i | input | 1 | Host reported already out of reset |
| phy_por_o | output | 1 | PHY power-on reset |
| phy_rst_o | output | 1 | PHY reset control |
| host_rst_n_o | output | 1 | Host reset release (1 = running) |
| hdiv_en_o | output | 1 | Host divider enable |
| hdiv_rst_n_o | output | 1 | Host divider reset release |
| ldiv_en_o | output | 1 | Low-speed divider enable |
| ldiv_rst_n_o | output | 1 | Low-speed divider reset release |
| refclk_ext_o | output | 1 | Reference select, 1 = external |
| refclk_div_o | output | 2 | Reference divider code |
| hclk_div_o | output | 4 | Host divider value |
| rate_err_o | output | 1 | Unsupported reference rate seen |
| frame_adj_o | output | 6 | Micro-frame length adjust |
| ref_cnt_o | output | CNT_W | Start/stop reference count |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All control outputs are registered.
- The count change and the first launch step (R2, R5) are due at the first edge after the strobe.
- On the skip path, `done_o` is due one edge later.
- The reference and divider fields settle within four edges of launch.

The bench therefore samples them on the falling edge after the relevant rising edge. For the timed steps, a monitor stamps the cycle number of every output transition on the falling edge, and the checks compare differences of those stamps with the intervals of R8–R11. Those checks do not depend on absolute start times.

// File: rtl/usb_pwrup_pkg.sv
package usb_pwrup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_REF, ST_HDIV, ST_HEN, ST_HRUN, ST_WPOR, ST_WPHY,
        ST_LEN, ST_WLDIV, ST_WP1, ST_WP0, ST_WP2, ST_FLA
    } seq_st_e;

    localparam logic [5:0] FRAME_ADJ_VAL = 6'h20;

    typedef struct packed {
        logic       por;
        logic       prst;
        logic       hrstn;
        logic       hen;
        logic       hrn;
        logic       len;
        logic       lrn;
        logic       ext;
        logic [1:0] rdiv;
        logic [3:0] hdiv;
        logic       err;
        logic [5:0] fla;
        logic       done;
    } ctl_s;

endpackage

// File: rtl/usb_pwrup_refcnt.sv
module usb_pwrup_refcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             first_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i && !stop_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        else if (stop_i && !start_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o   = cnt_q;
    assign first_o = start_i && !stop_i && (cnt_q == '0);

    p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && start_i) |=> cnt_q == CNT_MAX);
    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && stop_i) |=> cnt_q == '0);
endmodule

// File: rtl/usb_pwrup_hdiv.sv
module usb_pwrup_hdiv #(
    parameter int IO_W = 16
) (
    input  logic [IO_W-1:0] io_mhz_i,
    output logic [3:0]      hdiv_o
);
    localparam int STEP_MHZ = 130;

    logic [IO_W-1:0] base;

    always_comb begin
        base = io_mhz_i / IO_W'(STEP_MHZ);
        if (base == '0)                     hdiv_o = 4'd1;
        else if (base <= IO_W'(4))          hdiv_o = base[3:0];
        else if (base == IO_W'(5))          hdiv_o = 4'd4;
        else if (base <= IO_W'(7))          hdiv_o = 4'd6;
        else if (base <= IO_W'(11))         hdiv_o = 4'd8;
        else                                hdiv_o = 4'd12;
    end
endmodule

// File: rtl/usb_pwrup_timer.sv
module usb_pwrup_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)             cnt_d = val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    p_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq
    import usb_pwrup_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int US_PER_MS  = 1000,
    parameter int IO_WAIT    = 64,
    parameter int CNT_W      = 4,
    parameter int IO_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             crystal_i,
    input  logic [7:0]       ref_mhz_i,
    input  logic [IO_W-1:0]  io_mhz_i,
    input  logic             already_up_i,
    output logic             phy_por_o,
    output logic             phy_rst_o,
    output logic             host_rst_n_o,
    output logic             hdiv_en_o,
    output logic             hdiv_rst_n_o,
    output logic             ldiv_en_o,
    output logic             ldiv_rst_n_o,
    output logic             refclk_ext_o,
    output logic [1:0]       refclk_div_o,
    output logic [3:0]       hclk_div_o,
    output logic             rate_err_o,
    output logic [5:0]       frame_adj_o,
    output logic [CNT_W-1:0] ref_cnt_o,
    output logic             done_o
);
    localparam int MS_CYC  = US_PER_MS * CYC_PER_US;
    localparam int PHY_CYC = 3 * MS_CYC;
    localparam int MAX_CYC = (PHY_CYC > IO_WAIT) ? PHY_CYC : IO_WAIT;
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] LD_IO  = TW'(IO_WAIT - 1);
    localparam logic [TW-1:0] LD_PHY = TW'(PHY_CYC - 1);
    localparam logic [TW-1:0] LD_US  = TW'(CYC_PER_US - 1);
    localparam logic [TW-1:0] LD_MS  = TW'(MS_CYC - 1);

    seq_st_e       st_d, st_q;
    ctl_s          c_d, c_q;
    logic          launch, t_zero, t_load;
    logic [TW-1:0] t_val;
    logic [3:0]    hdiv_w;

    usb_pwrup_refcnt #(.CNT_W(CNT_W)) u_refcnt (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .cnt_o(ref_cnt_o), .first_o(launch)
    );

    usb_pwrup_hdiv #(.IO_W(IO_W)) u_hdiv (
        .io_mhz_i(io_mhz_i), .hdiv_o(hdiv_w)
    );

    usb_pwrup_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val), .zero_o(t_zero)
    );

    always_comb begin
        st_d   = st_q;
        c_d    = c_q;
        c_d.done = 1'b0;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st_q)
            ST_IDLE: if (launch) begin
                if (already_up_i || c_q.hrstn) begin
                    st_d = ST_FLA;
                end else begin
                    c_d.por   = 1'b1;
                    c_d.prst  = 1'b0;
                    c_d.hrstn = 1'b0;
                    c_d.hen   = 1'b0;
                    c_d.hrn   = 1'b0;
                    c_d.len   = 1'b0;
                    c_d.lrn   = 1'b0;
                    c_d.err   = 1'b0;
                    st_d      = ST_REF;
                end
            end
            ST_REF: begin
                c_d.ext = !crystal_i;
                case (ref_mhz_i)
                    8'd12:   c_d.rdiv = 2'd0;
                    8'd24:   c_d.rdiv = 2'd1;
                    8'd48:   c_d.rdiv = 2'd2;
                    default: begin
                        c_d.rdiv = 2'd0;
                        c_d.err  = 1'b1;
                    end
                endcase
                st_d = ST_HDIV;
            end
            ST_HDIV: begin
                c_d.hdiv = hdiv_w;
                st_d     = ST_HEN;
            end
            ST_HEN: begin
                c_d.hen = 1'b1;
                st_d    = ST_HRUN;
            end
            ST_HRUN: begin
                c_d.hrn = 1'b1;
                t_load  = 1'b1;
                t_val   = LD_IO;
                st_d    = ST_WPOR;
            end
            ST_WPOR: if (t_zero) begin
                c_d.por = 1'b0;
                t_load  = 1'b1;
                t_val   = LD_PHY;
                st_d    = ST_WPHY;
            end
            ST_WPHY: if (t_zero) begin
                c_d.lrn = 1'b1;
                st_d    = ST_LEN;
            end
            ST_LEN: begin
                c_d.len = 1'b1;
                t_load  = 1'b1;
                t_val   = LD_IO;
                st_d    = ST_WLDIV;
            end
            ST_WLDIV: if (t_zero) begin
                c_d.prst = 1'b1;
                t_load   = 1'b1;
                t_val    = LD_US;
                st_d     = ST_WP1;
            end
            ST_WP1: if (t_zero) begin
                c_d.prst = 1'b0;
                t_load   = 1'b1;
                t_val    = LD_MS;
                st_d     = ST_WP0;
            end
            ST_WP0: if (t_zero) begin
                c_d.prst = 1'b1;
                t_load   = 1'b1;
                t_val    = LD_US;
                st_d     = ST_WP2;
            end
            ST_WP2: if (t_zero) begin
                c_d.hrstn = 1'b1;
                st_d      = ST_FLA;
            end
            ST_FLA: begin
                c_d.fla  = FRAME_ADJ_VAL;
                c_d.done = 1'b1;
                st_d     = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            c_q  <= '0;
        end else begin
            st_q <= st_d;
            c_q  <= c_d;
        end
    end

    assign phy_por_o    = c_q.por;
    assign phy_rst_o    = c_q.prst;
    assign host_rst_n_o = c_q.hrstn;
    assign hdiv_en_o    = c_q.hen;
    assign hdiv_rst_n_o = c_q.hrn;
    assign ldiv_en_o    = c_q.len;
    assign ldiv_rst_n_o = c_q.lrn;
    assign refclk_ext_o = c_q.ext;
    assign refclk_div_o = c_q.rdiv;
    assign hclk_div_o   = c_q.hdiv;
    assign rate_err_o   = c_q.err;
    assign frame_adj_o  = c_q.fla;
    assign done_o       = c_q.done;

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |=> !c_q.done);
    p_host_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.hrstn) |-> (c_q.prst && !c_q.por && c_q.len && c_q.lrn && c_q.hen));
    p_por_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.por) |-> (c_q.hen && c_q.hrn));
    p_hdiv_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.hdiv != 4'd0) |-> (c_q.hdiv inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12}));
    p_skip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && launch && (already_up_i || c_q.hrstn))
        |=> ($stable(c_q.por) && $stable(c_q.prst) && $stable(c_q.hrstn) && $stable(c_q.hen)));
endmodule

// File: tb/usb_pwrup_seq_bench.sv
module usb_pwrup_seq_bench;
    localparam int CPU = 2;
    localparam int UPM = 20;
    localparam int IOW = 64;
    localparam int CW  = 2;
    localparam int MSC = UPM * CPU;
    localparam int PHC = 3 * MSC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0, crystal_i = 1'b0, already_up_i = 1'b0;
    logic [7:0]  ref_mhz_i = 8'd12;
    logic [15:0] io_mhz_i = 16'd500;
    logic phy_por_o, phy_rst_o, host_rst_n_o, hdiv_en_o, hdiv_rst_n_o;
    logic ldiv_en_o, ldiv_rst_n_o, refclk_ext_o, rate_err_o, done_o;
    logic [1:0] refclk_div_o;
    logic [3:0] hclk_div_o;
    logic [5:0] frame_adj_o;
    logic [CW-1:0] ref_cnt_o;

    int checks = 0, failures = 0, cyc = 0;
    int t_hen, t_hrn, t_por, t_lrn, t_len, t_p1, t_p0, t_p2, t_host, prises;
    logic p_por, p_prst, p_host, p_hen, p_hrn, p_len, p_lrn;

    usb_pwrup_seq #(.CYC_PER_US(CPU), .US_PER_MS(UPM), .IO_WAIT(IOW), .CNT_W(CW), .IO_W(16))
    u_usb_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .crystal_i(crystal_i), .ref_mhz_i(ref_mhz_i), .io_mhz_i(io_mhz_i),
        .already_up_i(already_up_i), .phy_por_o(phy_por_o), .phy_rst_o(phy_rst_o),
        .host_rst_n_o(host_rst_n_o), .hdiv_en_o(hdiv_en_o), .hdiv_rst_n_o(hdiv_rst_n_o),
        .ldiv_en_o(ldiv_en_o), .ldiv_rst_n_o(ldiv_rst_n_o), .refclk_ext_o(refclk_ext_o),
        .refclk_div_o(refclk_div_o), .hclk_div_o(hclk_div_o), .rate_err_o(rate_err_o),
        .frame_adj_o(frame_adj_o), .ref_cnt_o(ref_cnt_o), .done_o(done_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!p_hen && hdiv_en_o)     t_hen = cyc;
        if (!p_hrn && hdiv_rst_n_o)  t_hrn = cyc;
        if (p_por && !phy_por_o)     t_por = cyc;
        if (!p_lrn && ldiv_rst_n_o)  t_lrn = cyc;
        if (!p_len && ldiv_en_o)     t_len = cyc;
        if (!p_prst && phy_rst_o) begin
            if (prises == 0) t_p1 = cyc; else t_p2 = cyc;
            prises = prises + 1;
        end
        if (p_prst && !phy_rst_o)    t_p0 = cyc;
        if (!p_host && host_rst_n_o) t_host = cyc;
        p_por = phy_por_o; p_prst = phy_rst_o; p_host = host_rst_n_o;
        p_hen = hdiv_en_o; p_hrn = hdiv_rst_n_o; p_len = ldiv_en_o; p_lrn = ldiv_rst_n_o;
    end

    function automatic int exp_hdiv(int io);
        int b = io / 130;
        if (b == 0) return 1;
        if (b <= 4) return b;
        if (b == 5) return 4;
        if (b <= 7) return 6;
        if (b <= 11) return 8;
        return 12;
    endfunction

    function automatic int exp_rdiv(int r);
        if (r == 24) return 1;
        if (r == 48) return 2;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_i = 0; stop_i = 0; already_up_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        p_por = 0; p_prst = 0; p_host = 0; p_hen = 0; p_hrn = 0; p_len = 0; p_lrn = 0;
        prises = 0;
        t_hen = -1; t_hrn = -1; t_por = -1; t_lrn = -1; t_len = -1;
        t_p1 = -1; t_p0 = -1; t_p2 = -1; t_host = -1;
    endtask

    task automatic pulse(input logic s, input logic p);
        start_i = s; stop_i = p;
        @(negedge clk);
        start_i = 0; stop_i = 0;
    endtask

    task automatic full_run(input logic xtal, input int rmhz, input int io);
        int t_done = -1;
        do_reset();
        crystal_i = xtal; ref_mhz_i = 8'(rmhz); io_mhz_i = 16'(io);
        pulse(1'b1, 1'b0);
        check(phy_por_o == 1 && host_rst_n_o == 0 && phy_rst_o == 0 && hdiv_en_o == 0,
              "R5 init step", int'(phy_por_o), 1);
        check(ref_cnt_o == 1, "R2 first start count", int'(ref_cnt_o), 1);
        for (int k = 0; k < 3000 && !done_o; k++) @(negedge clk);
        t_done = cyc;
        check(done_o == 1, "R11 done seen", int'(done_o), 1);
        check(refclk_ext_o == !xtal, "R6 ref select", int'(refclk_ext_o), int'(!xtal));
        check(refclk_div_o == 2'(exp_rdiv(rmhz)), "R6 ref div", int'(refclk_div_o), exp_rdiv(rmhz));
        check(rate_err_o == !(rmhz == 12 || rmhz == 24 || rmhz == 48), "R6 rate error",
              int'(rate_err_o), int'(!(rmhz == 12 || rmhz == 24 || rmhz == 48)));
        check(int'(hclk_div_o) == exp_hdiv(io), "R7 host divider", int'(hclk_div_o), exp_hdiv(io));
        check(t_hrn - t_hen == 1, "R8 enable before release", t_hrn - t_hen, 1);
        check(t_por - t_hrn == IOW, "R8 por wait", t_por - t_hrn, IOW);
        check(t_lrn - t_por == PHC, "R9 3ms wait", t_lrn - t_por, PHC);
        check(t_len - t_lrn == 1, "R9 low divider enable", t_len - t_lrn, 1);
        check(t_p1 - t_len == IOW, "R9 low divider wait", t_p1 - t_len, IOW);
        check(t_p0 - t_p1 == CPU, "R10 phy high 1us", t_p0 - t_p1, CPU);
        check(t_p2 - t_p0 == MSC, "R10 phy low 1ms", t_p2 - t_p0, MSC);
        check(t_host - t_p2 == CPU, "R10 host release", t_host - t_p2, CPU);
        check(t_done - t_host == 1, "R11 done after host", t_done - t_host, 1);
        check(frame_adj_o == 6'h20, "R11 frame adjust", int'(frame_adj_o), 32);
        @(negedge clk);
        check(done_o == 0, "R11 one-cycle done", int'(done_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int io, rm;
        void'($urandom(32'd4242));
        do_reset();
        // R1 reset state
        check({phy_por_o, phy_rst_o, host_rst_n_o, hdiv_en_o, hdiv_rst_n_o, ldiv_en_o,
               ldiv_rst_n_o, done_o, rate_err_o} == '0 && ref_cnt_o == 0 && frame_adj_o == 0,
              "R1 reset outputs", int'(phy_por_o), 0);

        // directed divider corners and all reference rates
        full_run(1'b1, 12, 0);
        full_run(1'b0, 24, 129);
        full_run(1'b1, 48, 649);
        full_run(1'b0, 33, 650);
        full_run(1'b1, 12, 1040);
        full_run(1'b0, 24, 1559);
        full_run(1'b1, 48, 1560);
        for (int n = 0; n < 6; n++) begin
            io = int'($urandom % 2200);
            case ($urandom % 4)
                0: rm = 12; 1: rm = 24; 2: rm = 48;
                default: rm = int'($urandom % 256);
            endcase
            full_run(1'($urandom % 2), rm, io);
        end

        // R2 later starts only count, no rerun
        pulse(1'b1, 1'b0);
        check(ref_cnt_o == 2, "R2 second start count", int'(ref_cnt_o), 2);
        repeat (4) begin
            check(done_o == 0 && phy_por_o == 0 && phy_rst_o == 1, "R2 no rerun", int'(done_o), 0);
            @(negedge clk);
        end
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        check(ref_cnt_o == 3, "R3 saturate at max", int'(ref_cnt_o), 3);
        pulse(1'b1, 1'b1);
        check(ref_cnt_o == 3, "R2 start with stop no change", int'(ref_cnt_o), 3);
        pulse(1'b0, 1'b1);
        check(ref_cnt_o == 2, "R2 stop decrements", int'(ref_cnt_o), 2);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        check(ref_cnt_o == 0, "R3 stop at zero ignored", int'(ref_cnt_o), 0);

        // R4 restart while host already running: skip
        pulse(1'b1, 1'b0);
        check(done_o == 0 && ref_cnt_o == 1, "R4 skip launch edge", int'(done_o), 0);
        @(negedge clk);
        check(done_o == 1 && phy_por_o == 0 && host_rst_n_o == 1 && phy_rst_o == 1,
              "R4 skip done", int'(done_o), 1);

        // R4 with already_up_i on fresh reset
        do_reset();
        already_up_i = 1'b1;
        pulse(1'b1, 1'b0);
        check(phy_por_o == 0, "R4 external already up no por", int'(phy_por_o), 0);
        @(negedge clk);
        check(done_o == 1 && frame_adj_o == 6'h20 && host_rst_n_o == 0,
              "R4 external skip done", int'(frame_adj_o), 32);
        already_up_i = 1'b0;

        // R2 start with stop at zero launches nothing
        do_reset();
        pulse(1'b1, 1'b1);
        check(ref_cnt_o == 0 && phy_por_o == 0, "R2 simultaneous at zero", int'(phy_por_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule